// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block sits between a processor core and an external bus whose low sixteen lines carry an address first and data afterwards. Four upper lines carry the top address bits first and a status nibble afterwards. The internal side raises a request that carries an address, write data and three flags: write, byte and I/O. The sequencer then runs one transfer through the clock states T1, T2, T3, any number of wait states (TW) and T4. During that transfer it produces the address-latch strobe, the read and write strobes, the transceiver enable and the transceiver direction. It acknowledges the internal side for one clock in T4. Read data is returned alongside that acknowledge.

The states are named IDLE, T1, T2, T3, TW and T4. The transitions are as follows:
- IDLE goes to T1 when a request is present.
- T1 goes to T2, and T2 goes to T3.
- T3 goes to T4 when the ready input is high. Otherwise it goes to TW.
- TW stays in TW while ready is low and goes to T4 once ready is high.
- T4 always returns to IDLE, so two transfers are always separated by at least one idle clock.

A reset should be held for four clocks or more. When reset is released, the sequencer is in IDLE.

Top module: `mxb_sequencer`

## Requirements
- R1: While reset is high and in IDLE afterwards, the outputs are at rest:
  - `latch_stb` is 0, `mux_oe` is 0 and `ack` is 0.
  - `rdstb_n`, `wrstb_n`, `xcvr_en_n` and `hi_en_n` are 1.
  - `top_out` is 0 and `xmit_dir` is 0.
- R2: A request that is seen at a clock edge in IDLE starts T1 at that edge. T2 and T3 follow on the next two edges. With ready high at the end of T3, the cycle after T3 is T4.
- R3: In T1, `latch_stb` is 1 for exactly that one clock, `mux_oe` is 1, and `mux_out` equals address bits 15..0.
- R4: In T1, `top_out` carries address bits 19..16 for a memory transfer and 0 for an I/O transfer. In T2, T3, TW and T4 it carries the status nibble {io, wr, byte, 1}, where bit 3 is io and bit 0 is the constant 1.
- R5: In T1, `hi_en_n` is 0 when the transfer is a word (byte flag 0) or the address is odd (bit 0 = 1). It is 1 otherwise, and it is 1 in every other state.
- R6: Ready is sampled at the end of T3 and at the end of each TW. Each sample that is low adds one TW clock, so the acknowledge comes N clocks later for N low samples.
- R7: For a read, `rdstb_n` is 0 in T2, T3 and TW, and `xmit_dir` is 0. `rdata` holds the value of `mux_in` at the edge where ready is sampled high, and it is valid in T4.
- R8: For a write:
  - `mux_oe` is 1 and `mux_out` equals the write data in T2, T3, TW and T4.
  - `wrstb_n` is 0 in T2, T3 and TW.
  - `xmit_dir` is 1 from T1 through T4.
  - `rdstb_n` and `wrstb_n` are never both 0.
- R9: `xcvr_en_n` is 0 in T2, T3, TW and T4, and it is 1 in IDLE and T1.
- R10: `ack` is 1 for exactly one clock, in T4. A request is taken only in IDLE, so a request held high through T4 starts its T1 two clocks after the T4 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transfer request from the internal side |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock acknowledge in T4 |
| rdata | output | 16 | Read data captured when ready is sampled high |
| rdy_in | input | 1 | Ready input from the addressed device |
| mux_in | input | 16 | Value seen on the shared address/data lines |
| mux_out | output | 16 | Value driven onto the shared address/data lines |
| mux_oe | output | 1 | Output enable for the shared lines |
| top_out | output | 4 | Upper address bits in T1, status nibble in T2 through T4 |
| hi_en_n | output | 1 | Upper byte-lane enable in T1, active low |
| latch_stb | output | 1 | Address-latch strobe, high in T1 |
| rdstb_n | output | 1 | Read strobe, active low |
| wrstb_n | output | 1 | Write strobe, active low |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| xmit_dir | output | 1 | Transceiver direction, 1 = transmit |

## Verification
The acknowledge in T4 and the intake of a new request can fall close together when the internal side keeps its request high through T4. The bench provokes this by walking its vector table with the request never dropped. It then judges that `latch_stb` stays low in the clock after T4 and rises one clock later. A second coincidence is the read-data capture and the final ready sample at the same edge. The bench changes `mux_in` along with ready, so that a capture one edge early or one edge late returns the wrong value.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_st_t;
endpackage

// File: rtl/mxb_fsm.sv
module mxb_fsm
    import mxb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    rdy_in,
    output bus_st_t state,
    output logic    take,
    output logic    rdy_done
);
    bus_st_t nxt;

    assign take     = (state == ST_IDLE) && req;
    assign rdy_done = ((state == ST_T3) || (state == ST_TW)) && rdy_in;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = req ? ST_T1 : ST_IDLE;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = rdy_in ? ST_T4 : ST_TW;
            ST_TW:   nxt = rdy_in ? ST_T4 : ST_TW;
            ST_T4:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R6: a low ready at the end of T3 leads into a wait state
    assert_wait_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T3 && !rdy_in) |=> (state == ST_TW));

    // R6: a wait state persists while ready stays low
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TW && !rdy_in) |=> (state == ST_TW));

    // R2: T1 always advances to T2
    assert_t1_to_t2_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T1) |=> (state == ST_T2));
endmodule

// File: rtl/mxb_reqlat.sv
module mxb_reqlat #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          req_wr,
    input  logic          req_byte,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          l_wr,
    output logic          l_byte,
    output logic          l_io,
    output logic [AW-1:0] l_addr,
    output logic [DW-1:0] l_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            l_wr    <= 1'b0;
            l_byte  <= 1'b0;
            l_io    <= 1'b0;
            l_addr  <= '0;
            l_wdata <= '0;
        end else if (take) begin
            l_wr    <= req_wr;
            l_byte  <= req_byte;
            l_io    <= req_io;
            l_addr  <= req_addr;
            l_wdata <= req_wdata;
        end
    end
endmodule

// File: rtl/mxb_rdcap.sv
module mxb_rdcap #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [DW-1:0] mux_in,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)      rdata <= '0;
        else if (cap) rdata <= mux_in;
    end
endmodule

// File: rtl/mxb_pins.sv
module mxb_pins
    import mxb_pkg::*;
#(
    parameter int DW   = 16,
    parameter int TOPW = 4,
    localparam int AW  = DW + TOPW
) (
    input  bus_st_t         state,
    input  logic            l_wr,
    input  logic            l_byte,
    input  logic            l_io,
    input  logic [AW-1:0]   l_addr,
    input  logic [DW-1:0]   l_wdata,
    output logic [DW-1:0]   mux_out,
    output logic            mux_oe,
    output logic [TOPW-1:0] top_out,
    output logic            hi_en_n,
    output logic            latch_stb,
    output logic            rdstb_n,
    output logic            wrstb_n,
    output logic            xcvr_en_n,
    output logic            xmit_dir,
    output logic            ack
);
    logic [TOPW-1:0] stat_code;
    assign stat_code = TOPW'({l_io, l_wr, l_byte, 1'b1});

    always_comb begin
        mux_out   = '0;
        mux_oe    = 1'b0;
        top_out   = '0;
        hi_en_n   = 1'b1;
        latch_stb = 1'b0;
        rdstb_n   = 1'b1;
        wrstb_n   = 1'b1;
        xcvr_en_n = 1'b1;
        xmit_dir  = 1'b0;
        ack       = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_T1: begin
                latch_stb = 1'b1;
                mux_oe    = 1'b1;
                mux_out   = l_addr[DW-1:0];
                top_out   = l_io ? '0 : l_addr[AW-1:DW];
                hi_en_n   = ~(~l_byte | l_addr[0]);
                xmit_dir  = l_wr;
            end
            ST_T2, ST_T3, ST_TW: begin
                top_out   = stat_code;
                xcvr_en_n = 1'b0;
                xmit_dir  = l_wr;
                mux_oe    = l_wr;
                mux_out   = l_wr ? l_wdata : '0;
                rdstb_n   = l_wr;
                wrstb_n   = ~l_wr;
            end
            ST_T4: begin
                top_out   = stat_code;
                xcvr_en_n = 1'b0;
                xmit_dir  = l_wr;
                mux_oe    = l_wr;
                mux_out   = l_wr ? l_wdata : '0;
                ack       = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mxb_sequencer.sv
module mxb_sequencer
    import mxb_pkg::*;
#(
    parameter int DW   = 16,
    parameter int TOPW = 4,
    localparam int AW  = DW + TOPW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            req_wr,
    input  logic            req_byte,
    input  logic            req_io,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            ack,
    output logic [DW-1:0]   rdata,
    input  logic            rdy_in,
    input  logic [DW-1:0]   mux_in,
    output logic [DW-1:0]   mux_out,
    output logic            mux_oe,
    output logic [TOPW-1:0] top_out,
    output logic            hi_en_n,
    output logic            latch_stb,
    output logic            rdstb_n,
    output logic            wrstb_n,
    output logic            xcvr_en_n,
    output logic            xmit_dir
);
    bus_st_t         state;
    logic            take, rdy_done;
    logic            l_wr, l_byte, l_io;
    logic [AW-1:0]   l_addr;
    logic [DW-1:0]   l_wdata;

    mxb_fsm u_fsm (
        .clk(clk), .rst(rst), .req(req), .rdy_in(rdy_in),
        .state(state), .take(take), .rdy_done(rdy_done)
    );

    mxb_reqlat #(.AW(AW), .DW(DW)) u_lat (
        .clk(clk), .rst(rst), .take(take),
        .req_wr(req_wr), .req_byte(req_byte), .req_io(req_io),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .l_wr(l_wr), .l_byte(l_byte), .l_io(l_io),
        .l_addr(l_addr), .l_wdata(l_wdata)
    );

    mxb_rdcap #(.DW(DW)) u_cap (
        .clk(clk), .rst(rst), .cap(rdy_done && !l_wr),
        .mux_in(mux_in), .rdata(rdata)
    );

    mxb_pins #(.DW(DW), .TOPW(TOPW)) u_pins (
        .state(state), .l_wr(l_wr), .l_byte(l_byte), .l_io(l_io),
        .l_addr(l_addr), .l_wdata(l_wdata),
        .mux_out(mux_out), .mux_oe(mux_oe), .top_out(top_out),
        .hi_en_n(hi_en_n), .latch_stb(latch_stb), .rdstb_n(rdstb_n),
        .wrstb_n(wrstb_n), .xcvr_en_n(xcvr_en_n), .xmit_dir(xmit_dir),
        .ack(ack)
    );

    // R10: acknowledge lasts one clock
    assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R3: address latch strobe lasts one clock, then transceivers open (R9)
    assert_latch_then_xcvr_R3: assert property (@(posedge clk) disable iff (rst)
        latch_stb |=> (!latch_stb && !xcvr_en_n));

    // R8: read and write strobes never overlap
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(!rdstb_n && !wrstb_n));

    // R7: read strobe only with receive direction
    assert_read_dir_R7: assert property (@(posedge clk) disable iff (rst)
        !rdstb_n |-> !xmit_dir);

    // R1: idle state keeps the bus quiet
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (rdstb_n && wrstb_n && !mux_oe && xcvr_en_n && !ack));

    // R10: after the acknowledge no strobe follows in the next clock
    assert_gap_after_ack_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !latch_stb);
endmodule

// File: tb/mxb_sequencer_test.sv
`timescale 1ns/1ps
module mxb_sequencer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req, req_wr, req_byte, req_io, rdy_in;
    logic [19:0] req_addr;
    logic [15:0] req_wdata, mux_in;
    logic        ack, mux_oe, hi_en_n, latch_stb, rdstb_n, wrstb_n, xcvr_en_n, xmit_dir;
    logic [15:0] rdata, mux_out;
    logic [3:0]  top_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mxb_sequencer uut (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_byte(req_byte),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata), .rdy_in(rdy_in), .mux_in(mux_in),
        .mux_out(mux_out), .mux_oe(mux_oe), .top_out(top_out), .hi_en_n(hi_en_n),
        .latch_stb(latch_stb), .rdstb_n(rdstb_n), .wrstb_n(wrstb_n),
        .xcvr_en_n(xcvr_en_n), .xmit_dir(xmit_dir)
    );

    // vector: {wr, byte, io, addr[19:0], wdata[15:0], nwait[2:0], rdval[15:0]}
    localparam int NV = 8;
    localparam logic [57:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 20'hA5432, 16'h0000, 3'd0, 16'h1234},
        {1'b1, 1'b0, 1'b0, 20'h3C0F0, 16'hBEEF, 3'd0, 16'h0000},
        {1'b0, 1'b1, 1'b0, 20'h70001, 16'h0000, 3'd2, 16'h5A5A},
        {1'b1, 1'b1, 1'b1, 20'hFFF7E, 16'h00C3, 3'd1, 16'h0000},
        {1'b0, 1'b1, 1'b1, 20'h9ABCD, 16'h0000, 3'd3, 16'hC0DE},
        {1'b1, 1'b0, 1'b1, 20'h81234, 16'h7E81, 3'd4, 16'h0000},
        {1'b0, 1'b1, 1'b0, 20'h12340, 16'h0000, 3'd0, 16'h8001},
        {1'b1, 1'b1, 1'b0, 20'hE0003, 16'h4321, 3'd7, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " latch"}, latch_stb, 0);
        chk({tag, " oe"}, mux_oe, 0);
        chk({tag, " ack"}, ack, 0);
        chk({tag, " rd"}, rdstb_n, 1);
        chk({tag, " wr"}, wrstb_n, 1);
        chk({tag, " xcvr"}, xcvr_en_n, 1);
        chk({tag, " hi"}, hi_en_n, 1);
        chk({tag, " top"}, top_out, 0);
        chk({tag, " dir"}, xmit_dir, 0);
    endtask

    task automatic chk_mid(input logic wr, input logic [15:0] wd, input logic [3:0] st);
        chk("R3 latch low after T1", latch_stb, 0);
        chk("R4 status nibble", top_out, st);
        chk("R5 hi enable high", hi_en_n, 1);
        chk("R7 read strobe", rdstb_n, wr);
        chk("R8 write strobe", wrstb_n, !wr);
        chk("R8 direction", xmit_dir, wr);
        chk("R8 output enable", mux_oe, wr);
        if (wr) chk("R8 write data", mux_out, wd);
        chk("R9 xcvr enable", xcvr_en_n, 0);
        chk("R10 no ack before T4", ack, 0);
    endtask

    task automatic run_xfer(input logic [57:0] v, input bit hold);
        logic        wr, byt, io;
        logic [19:0] ad;
        logic [15:0] wd, rv;
        logic [2:0]  nw;
        logic [3:0]  st;
        {wr, byt, io, ad, wd, nw, rv} = v;
        st = {io, wr, byt, 1'b1};
        req = 1; req_wr = wr; req_byte = byt; req_io = io; req_addr = ad; req_wdata = wd;
        rdy_in = 0; mux_in = ~rv;
        @(negedge clk); // T1
        chk("R3 latch in T1", latch_stb, 1);
        chk("R3 oe in T1", mux_oe, 1);
        chk("R3 address low", mux_out, ad[15:0]);
        chk("R4 upper address", top_out, io ? 4'h0 : ad[19:16]);
        chk("R5 hi enable T1", hi_en_n, !(!byt || ad[0]));
        chk("R9 xcvr off T1", xcvr_en_n, 1);
        chk("R8 dir T1", xmit_dir, wr);
        req_wdata = ~wd; req_addr = ~ad;   // latched copy must be used
        @(negedge clk); // T2
        chk_mid(wr, wd, st);
        @(negedge clk); // T3
        chk_mid(wr, wd, st);
        rdy_in = (nw == 0); mux_in = (nw == 0) ? rv : ~rv;
        for (int i = 0; i < nw; i++) begin
            @(negedge clk); // TW
            chk_mid(wr, wd, st);
            rdy_in = (i == nw - 1); mux_in = (i == nw - 1) ? rv : ~rv;
        end
        @(negedge clk); // T4
        chk("R2 R6 ack in T4", ack, 1);
        chk("R7 read strobe off T4", rdstb_n, 1);
        chk("R8 write strobe off T4", wrstb_n, 1);
        chk("R9 xcvr on T4", xcvr_en_n, 0);
        chk("R4 status T4", top_out, st);
        chk("R8 oe T4", mux_oe, wr);
        if (!wr) chk("R7 read data", rdata, rv);
        else     chk("R8 write data T4", mux_out, wd);
        rdy_in = 0; mux_in = 16'hDEAD;
        if (!hold) req = 0;
        @(negedge clk); // IDLE
        chk_idle("R10 idle after T4");
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; req = 0; req_wr = 0; req_byte = 0; req_io = 0;
        req_addr = 0; req_wdata = 0; rdy_in = 0; mux_in = 0;
        repeat (5) @(negedge clk);
        chk_idle("R1 during reset");
        rst = 0;
        @(negedge clk);
        chk_idle("R1 after reset");

        // table walk with the request held high between transfers (R10)
        for (int k = 0; k < NV; k++) run_xfer(VEC[k], k != NV - 1);

        // no request: stays idle
        repeat (3) @(negedge clk);
        chk_idle("R2 no request stays idle");

        // reset in the middle of a transfer
        req = 1; req_wr = 1; req_byte = 0; req_io = 0; req_addr = 20'h12345; req_wdata = 16'hAAAA;
        @(negedge clk);
        @(negedge clk);
        req = 0; rst = 1;
        repeat (4) @(negedge clk);
        chk_idle("R1 reset mid transfer");
        rst = 0;
        @(negedge clk);
        chk_idle("R1 idle after mid reset");

        // long wait read after reset
        run_xfer({1'b0, 1'b0, 1'b1, 20'h00FFE, 16'h0000, 3'd6, 16'h6B6B}, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule